// File: doc/BRIEF.md
# Address-Match Busy Arbiter

Two independent memory ports share one storage array. This block watches both ports' selects and addresses. When both ports are selected at the same full address, it picks one port to proceed and pulls the other port's active-low busy flag, so the losing port can stall and its write is blocked inside the array. The decision depends only on addresses and selects. The read or write intent of an access plays no part in it.

Arrival order is measured in clock cycles. A port whose select and address were already in place on the previous cycle beats a port that only reached the matching address on this cycle. When both ports reach the match on the same cycle, the grant alternates between the ports from one such tie to the next. The owner holds the grant for as long as the match lasts.

A mode input sets the block's role. In master mode the block arbitrates and drives both busy flags. In slave mode it drives no busy indication, and each port's incoming busy line serves only as a write inhibit for that port. Several slaves can then follow one master's decision.

Top module: `busy_arbiter`

## Requirements
- R1: In master mode both busy outputs stay high unless both selects are low and the two full addresses are equal.
- R2: When a match forms and exactly one port has held its select low with an unchanged address since the previous cycle, that port wins. The other port's busy goes low in the same cycle the match forms.
- R3: When neither port, or both ports, held steady from the previous cycle as the match forms, the match is a tie. The first tie after reset goes to port A, so b_busy_n goes low. Each later tie goes to the port that lost the previous tie.
- R4: a_busy_n and b_busy_n are never low together.
- R5: The write-request inputs have no effect on either busy output.
- R6: The winner keeps the grant while the match holds. Busy returns high in the same cycle that either select goes high or the addresses differ.
- R7: In master mode a port's effective write (x_wr_eff = x_wr and not inhibited) is forced low exactly while that port's busy output is low. The busy input pins are ignored in this mode.
- R8: In slave mode (master_mode = 0) both busy outputs stay high. Each port's effective write is forced low exactly while that port's busy input is low.
- R9: During and right after reset both busy outputs are high, and the tie preference points at port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = follow busy inputs |
| a_sel_n | input | 1 | Port A select, active low |
| a_addr | input | ADDR_W | Port A address |
| a_wr | input | 1 | Port A write request |
| a_busy_in_n | input | 1 | Port A busy from a master, used in slave mode |
| b_sel_n | input | 1 | Port B select, active low |
| b_addr | input | ADDR_W | Port B address |
| b_wr | input | 1 | Port B write request |
| b_busy_in_n | input | 1 | Port B busy from a master, used in slave mode |
| a_busy_n | output | 1 | Port A busy, active low |
| b_busy_n | output | 1 | Port B busy, active low |
| a_wr_eff | output | 1 | Port A write after inhibit |
| b_wr_eff | output | 1 | Port B write after inhibit |

## Verification
The bench targets a staggered arrival in each direction. A design that ignores arrival order would grant the later port. It also runs a series of same-cycle ties. A design without alternation would keep handing every tie to one port, and a design without hold would let the winner change while the match lasts. Releases through a select going high and through an address change catch a design that keeps busy low after the match has gone. Slave-mode runs and master runs with the busy input pins pulled low catch a design that takes its write inhibit from the wrong source. A long random phase over a two-address space checks every cycle that the two busy flags never go low together.

// File: rtl/busy_arbiter.sv
module busy_arbiter #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              a_sel_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_busy_in_n,
  input  logic              b_sel_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_busy_in_n,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_wr_eff,
  output logic              b_wr_eff
);

  typedef enum logic [1:0] {OWN_NONE, OWN_A, OWN_B} own_t;

  own_t              owner_q, grant;
  logic              tie_b_q, tie;
  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic              a_was_sel, b_was_sel;
  logic              a_held, b_held, match;
  logic              a_block, b_block;

  assign a_held = !a_sel_n && a_was_sel && (a_addr == a_addr_q);
  assign b_held = !b_sel_n && b_was_sel && (b_addr == b_addr_q);
  assign match  = rst_n && master_mode && !a_sel_n && !b_sel_n && (a_addr == b_addr);

  always_comb begin
    grant = owner_q;
    tie   = 1'b0;
    if (!match) begin
      grant = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      if (a_held && !b_held)      grant = OWN_A;
      else if (b_held && !a_held) grant = OWN_B;
      else begin
        tie   = 1'b1;
        grant = tie_b_q ? OWN_B : OWN_A;
      end
    end
  end

  assign a_busy_n = (grant != OWN_B);
  assign b_busy_n = (grant != OWN_A);

  assign a_block  = master_mode ? !a_busy_n : !a_busy_in_n;
  assign b_block  = master_mode ? !b_busy_n : !b_busy_in_n;
  assign a_wr_eff = a_wr && !a_block;
  assign b_wr_eff = b_wr && !b_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= OWN_NONE;
      tie_b_q   <= 1'b0;
      a_was_sel <= 1'b0;
      b_was_sel <= 1'b0;
      a_addr_q  <= '0;
      b_addr_q  <= '0;
    end else begin
      owner_q   <= grant;
      if (tie) tie_b_q <= !tie_b_q;
      a_was_sel <= !a_sel_n;
      b_was_sel <= !b_sel_n;
      a_addr_q  <= a_addr;
      b_addr_q  <= b_addr;
    end
  end

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_busy_n || b_busy_n);

  p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel_n || b_sel_n || (a_addr != b_addr)) |-> (a_busy_n && b_busy_n));

  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (a_busy_n && b_busy_n));

  p_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_busy_n && master_mode && !a_sel_n && !b_sel_n && (a_addr == b_addr))
      |=> ((master_mode && !a_sel_n && !b_sel_n && (a_addr == b_addr)) -> !b_busy_n));

  p_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_busy_n && master_mode && !a_sel_n && !b_sel_n && (a_addr == b_addr))
      |=> ((master_mode && !a_sel_n && !b_sel_n && (a_addr == b_addr)) -> !a_busy_n));

  p_wr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !a_busy_n) |-> !a_wr_eff);

  p_slave_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !b_busy_in_n) |-> !b_wr_eff);

endmodule

// File: tb/busy_arbiter_tb.sv
module busy_arbiter_tb_top;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mm = 1'b1;
  logic as_n = 1'b1, bs_n = 1'b1;
  logic [AW-1:0] aa = '0, ba = '0;
  logic aw = 1'b0, bw = 1'b0;
  logic abi_n = 1'b1, bbi_n = 1'b1;
  logic a_busy_n, b_busy_n, a_wr_eff, b_wr_eff;

  int n_chk = 0, n_fail = 0;

  int own = 0;
  bit tie_b = 0;
  bit pa_sel = 0, pb_sel = 0;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  int g_next = 0;
  bit tie_now = 0;

  always #10 clk = ~clk;

  busy_arbiter #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(mm),
    .a_sel_n(as_n), .a_addr(aa), .a_wr(aw), .a_busy_in_n(abi_n),
    .b_sel_n(bs_n), .b_addr(ba), .b_wr(bw), .b_busy_in_n(bbi_n),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
    .a_wr_eff(a_wr_eff), .b_wr_eff(b_wr_eff));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick(input string tag);
    bit m, ah, bh, ebsa, ebsb, blka, blkb;
    #5;
    m = rst_n && mm && !as_n && !bs_n && (aa == ba);
    tie_now = 0;
    if (!m) g_next = 0;
    else if (own != 0) g_next = own;
    else begin
      ah = !as_n && pa_sel && (aa == pa_addr);
      bh = !bs_n && pb_sel && (ba == pb_addr);
      if (ah && !bh) g_next = 1;
      else if (bh && !ah) g_next = 2;
      else begin g_next = tie_b ? 2 : 1; tie_now = 1; end
    end
    ebsa = (g_next != 2);
    ebsb = (g_next != 1);
    blka = mm ? !ebsa : !abi_n;
    blkb = mm ? !ebsb : !bbi_n;
    chk(tag, {a_busy_n, b_busy_n, a_wr_eff, b_wr_eff},
        {ebsa, ebsb, aw && !blka, bw && !blkb});
    chk("R4", {3'b000, a_busy_n | b_busy_n}, 4'b0001);
    @(posedge clk);
    if (rst_n) begin
      own = g_next;
      if (tie_now) tie_b = !tie_b;
      pa_sel = !as_n; pb_sel = !bs_n;
      pa_addr = aa;   pb_addr = ba;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    as_n = 1; bs_n = 1; aw = 0; bw = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    as_n = 0; bs_n = 0; aa = 14'h0042; ba = 14'h0042;
    #5;
    chk("R9 busy high in reset", {a_busy_n, b_busy_n, 2'b00}, 4'b1100);
    @(negedge clk);
    idle();
    rst_n = 1;
    tick("R9 after reset");

    as_n = 0; bs_n = 0; aa = 14'h0100; ba = 14'h0101; tick("R1 diff addr");
    bs_n = 1; ba = 14'h0100; tick("R1 one select");
    idle(); tick("R1 idle");

    as_n = 0; aa = 14'h0123; tick("R2 A alone");
    bs_n = 0; ba = 14'h0123; bw = 1; aw = 1; tick("R2 A first wins");
    bw = 0; tick("R5 wr ignored");
    bw = 1; aw = 0; tick("R7 B write blocked");
    aa = 14'h0124; tick("R6 release on addr change");
    idle(); tick("R6 idle");

    bs_n = 0; ba = 14'h3FFF; tick("R2 B alone");
    as_n = 0; aa = 14'h3FFF; aw = 1; tick("R2 B first wins");
    aw = 0; bw = 1; tick("R5 B write passes");
    tick("R6 hold");
    bs_n = 1; tick("R6 release on deselect");
    idle(); tick("R6 idle2");

    for (int i = 0; i < 4; i++) begin
      as_n = 0; bs_n = 0; aa = 14'h0007; ba = 14'h0007; aw = 1; bw = 1;
      tick("R3 tie");
      tick("R6 tie hold");
      idle(); tick("R3 gap");
    end

    as_n = 0; bs_n = 0; aa = 14'h0055; ba = 14'h0055; tick("R3 tie from settled");
    as_n = 1; tick("R6 drop");
    as_n = 0; tick("R2 B held wins");
    idle(); tick("R6 idle3");

    abi_n = 0; bbi_n = 0; aw = 1; bw = 1; tick("R7 inputs ignored");
    mm = 0; tick("R8 slave inhibit");
    abi_n = 1; tick("R8 slave A passes");
    as_n = 0; bs_n = 0; aa = 14'h0200; ba = 14'h0200; tick("R8 slave no busy");
    tick("R8 slave steady");
    bbi_n = 1; tick("R8 slave free");
    idle(); tick("R8 idle");
    mm = 1; tick("R1 back to master");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) as_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) bs_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) aa = AW'($urandom_range(5, 6));
      if ($urandom_range(0, 3) == 0) ba = AW'($urandom_range(5, 6));
      aw = 1'($urandom_range(0, 1));
      bw = 1'($urandom_range(0, 1));
      abi_n = 1'($urandom_range(0, 1));
      bbi_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 63) == 0) mm = !mm;
      tick("R4 random");
    end

    summary();
    $finish;
  end
endmodule